// File: doc/BRIEF.md
# Static/Dynamic Bus Cycle Media-Access Controller

This block is the media-access timing engine for one node on a shared, cycle-organised bus. Every bus cycle runs three segments back to back: a static segment of equal-length time-division slots, a dynamic segment built from minislots, and a waiting segment. All times count clock cycles. In each static slot a per-slot schedule entry tells the node to send, to receive or to stay quiet. In the dynamic segment a frame counter starts at zero and steps in the same way on every node. When the counter lands on a frame number that this node owns, the block picks a message from its local pending queue and starts sending it.

Pending dynamic messages sit in one queue of 8 entries. The queue is sorted by priority and keeps equal priorities in arrival order. On an owned frame the block takes the most urgent entry whose length fits in the minislots still left in the segment. An entry that does not fit stays queued for a later cycle. Transmit-start strobes carry a message number, plus a length for dynamic sends. Segment timing and the owned-frame mask come from configuration inputs. These inputs are captured only while the controller is disabled.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: `seg_o` shows the segment with the encoding 0 off, 1 static, 2 dynamic, 3 waiting. It reads 0 after reset and in any cycle that follows a clock edge with `enable_i` low. Once enabled, the segments always run static, then dynamic, then waiting, then static again.
- R2: During static slot s, `act_o` shows the schedule entry for s, with 0 idle, 1 send and 2 receive. It reads 0 outside the static segment. In the first cycle of a send slot, `stat_tx_o` pulses for one cycle with `tx_msg_o` set to the slot's scheduled message number and `tx_len_o` set to 0. Schedule entries are written through `sched_we_i`.
- R3: Each static slot lasts the configured slot length in cycles. The first clock edge with `enable_i` high starts slot 0. The static segment ends after the configured number of slots.
- R4: A minislot lasts the configured minislot length in cycles. `fid_o` starts at 0 at the start of the dynamic segment and reads 0 outside it. A frame number with no send uses exactly one minislot.
- R5: A dynamic send (`dyn_tx_o`) happens only in the first cycle of frame number f, and only when bit f of the owned-frame mask is set.
- R6: Among queued messages that fit, the one with the lowest priority value wins. Equal priorities are served in the order they were pushed.
- R7: A message fits when its length in minislots is less than or equal to the minislots left in the dynamic segment, counting the current one. An exact fit is sent. A message that does not fit stays queued, and if none fits, nothing is sent.
- R8: A frame whose message is sent spans as many minislots as the message length. The frame number then advances.
- R9: After the configured count of minislots, the waiting segment lasts the configured wait length in cycles. A new cycle then starts at static slot 0.
- R10: Changes on the configuration inputs while `enable_i` is high have no effect on timing or on frame ownership.
- R11: The queue holds 8 entries, and `q_full_o` is high when all 8 are used. A push while `q_full_o` is high is dropped, and so is a push with length 0. Queued messages survive disabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run bus cycles; low holds the block off and opens configuration capture |
| cfg_slot_len_i | input | TIME_W | Static slot length in cycles |
| cfg_static_slots_i | input | SIDX_W+1 | Number of static slots |
| cfg_minislot_len_i | input | TIME_W | Minislot length in cycles |
| cfg_dyn_minislots_i | input | MS_W | Dynamic segment length in minislots |
| cfg_wait_len_i | input | TIME_W | Waiting segment length in cycles |
| cfg_own_fid_i | input | NFID | Owned dynamic frame numbers, bit f for frame f |
| sched_we_i | input | 1 | Schedule entry write strobe |
| sched_addr_i | input | SIDX_W | Static slot to write |
| sched_act_i | input | 2 | Slot action: 0 idle, 1 send, 2 receive |
| sched_msg_i | input | IDX_W | Message number sent in that slot |
| push_i | input | 1 | Queue a dynamic message |
| push_prio_i | input | PRIO_W | Priority, lower value more urgent |
| push_len_i | input | MS_W | Length in minislots |
| push_msg_i | input | IDX_W | Message number |
| q_full_o | output | 1 | Queue holds 8 entries |
| seg_o | output | 2 | Current segment |
| slot_o | output | SIDX_W | Current static slot, 0 outside static |
| fid_o | output | MS_W | Current dynamic frame number, 0 outside dynamic |
| act_o | output | 2 | Current static slot action |
| stat_tx_o | output | 1 | Static transmit start |
| dyn_tx_o | output | 1 | Dynamic transmit start |
| tx_msg_o | output | IDX_W | Message number for the strobe |
| tx_len_o | output | MS_W | Dynamic message length, 0 otherwise |

## Verification
The first pattern runs two full bus cycles with a mixed queue. That queue holds two equal-priority entries, one entry that can never fit, and one zero-length push that must be dropped. The owned-frame mask skips frames, so the run separates owned frames from unowned ones and a fitting message from a too-long one of higher priority. It also checks that a send slot stretches over its length while an idle frame takes one minislot. The configuration inputs are scrambled during this run, which shows whether any capture happens while the block is enabled. A second pattern uses a three-minislot segment to test an exact fit and the segment end that follows the stretched slot. A third pattern pushes two equal-priority entries to confirm arrival order across cycles. A final pattern fills the queue and then pushes an urgent entry, which shows whether the full queue drops it.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic [1:0] {
    SEG_OFF    = 2'd0,
    SEG_STATIC = 2'd1,
    SEG_DYN    = 2'd2,
    SEG_WAIT   = 2'd3
  } seg_e;

  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_SEND = 2'd1,
    ACT_RECV = 2'd2
  } act_e;
endpackage

// File: rtl/bcc_sched_table.sv
module bcc_sched_table #(
  parameter int NSTAT = 16,
  parameter int IDX_W = 4,
  localparam int SIDX_W = $clog2(NSTAT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [SIDX_W-1:0] waddr_i,
  input  logic [1:0]        wact_i,
  input  logic [IDX_W-1:0]  wmsg_i,
  input  logic [SIDX_W-1:0] raddr_i,
  output logic [1:0]        ract_o,
  output logic [IDX_W-1:0]  rmsg_o
);
  logic [1:0]       act_q [NSTAT];
  logic [IDX_W-1:0] msg_q [NSTAT];

  for (genvar s = 0; s < NSTAT; s++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q[s] <= '0;
        msg_q[s] <= '0;
      end else if (we_i && waddr_i == SIDX_W'(s)) begin
        act_q[s] <= wact_i;
        msg_q[s] <= wmsg_i;
      end
    end
  end

  assign ract_o = act_q[raddr_i];
  assign rmsg_o = msg_q[raddr_i];
endmodule

// File: rtl/bcc_dyn_queue.sv
module bcc_dyn_queue #(
  parameter int DEPTH  = 8,
  parameter int PRIO_W = 3,
  parameter int LEN_W  = 8,
  parameter int IDX_W  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [LEN_W-1:0]  push_len_i,
  input  logic [IDX_W-1:0]  push_msg_i,
  input  logic [LEN_W-1:0]  room_i,
  input  logic              pop_i,
  output logic              sel_vld_o,
  output logic [LEN_W-1:0]  sel_len_o,
  output logic [IDX_W-1:0]  sel_msg_o,
  output logic              full_o
);
  // entries kept sorted: index 0 most urgent, ties in arrival order
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [LEN_W-1:0]  len_q  [DEPTH];
  logic [IDX_W-1:0]  msg_q  [DEPTH];
  logic [DEPTH-1:0]  vld_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [PRIO_W-1:0] r_prio [DEPTH];
  logic [LEN_W-1:0]  r_len  [DEPTH];
  logic [IDX_W-1:0]  r_msg  [DEPTH];
  logic [DEPTH-1:0]  r_vld;
  logic [PRIO_W-1:0] n_prio [DEPTH];
  logic [LEN_W-1:0]  n_len  [DEPTH];
  logic [IDX_W-1:0]  n_msg  [DEPTH];
  logic [DEPTH-1:0]  n_vld;
  logic [DEPTH-1:0]  hit;
  int                sel;
  int                pos;
  logic              pop_ok, push_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign push_ok = push_i && !full_o && (push_len_i != '0);

  always_comb begin
    sel       = 0;
    sel_len_o = '0;
    sel_msg_o = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      hit[k] = vld_q[k] && (len_q[k] <= room_i);
      if (hit[k]) begin
        sel       = k;
        sel_len_o = len_q[k];
        sel_msg_o = msg_q[k];
      end
    end
    sel_vld_o = |hit;
  end

  assign pop_ok = pop_i && sel_vld_o;

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      r_prio[k] = prio_q[k];
      r_len[k]  = len_q[k];
      r_msg[k]  = msg_q[k];
      r_vld[k]  = vld_q[k];
      if (pop_ok && k >= sel) begin
        if (k < DEPTH - 1) begin
          r_prio[k] = prio_q[k+1];
          r_len[k]  = len_q[k+1];
          r_msg[k]  = msg_q[k+1];
          r_vld[k]  = vld_q[k+1];
        end else begin
          r_prio[k] = '0;
          r_len[k]  = '0;
          r_msg[k]  = '0;
          r_vld[k]  = 1'b0;
        end
      end
    end
    pos = 0;
    for (int k = 0; k < DEPTH; k++) begin
      if (r_vld[k] && r_prio[k] <= push_prio_i) pos = k + 1;
    end
    for (int k = 0; k < DEPTH; k++) begin
      n_prio[k] = r_prio[k];
      n_len[k]  = r_len[k];
      n_msg[k]  = r_msg[k];
      n_vld[k]  = r_vld[k];
      if (push_ok) begin
        if (k == pos) begin
          n_prio[k] = push_prio_i;
          n_len[k]  = push_len_i;
          n_msg[k]  = push_msg_i;
          n_vld[k]  = 1'b1;
        end else if (k > pos && k > 0) begin
          n_prio[k] = r_prio[k-1];
          n_len[k]  = r_len[k-1];
          n_msg[k]  = r_msg[k-1];
          n_vld[k]  = r_vld[k-1];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) begin
        prio_q[k] <= '0;
        len_q[k]  <= '0;
        msg_q[k]  <= '0;
      end
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        prio_q[k] <= n_prio[k];
        len_q[k]  <= n_len[k];
        msg_q[k]  <= n_msg[k];
      end
      vld_q <= n_vld;
      cnt_q <= cnt_q - CNT_W'(pop_ok) + CNT_W'(push_ok);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)); // R11
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !pop_i |=> cnt_q == $past(cnt_q)); // R11
  AST_FIT_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_vld_o |-> sel_len_o <= room_i && sel_len_o != '0); // R7

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_ord
    AST_SORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[k+1] |-> vld_q[k] && prio_q[k] <= prio_q[k+1]); // R6
  end
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int NSTAT  = 16,
  parameter int TIME_W = 8,
  parameter int MS_W   = 8,
  parameter int NFID   = 16,
  parameter int QDEPTH = 8,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 4,
  localparam int SIDX_W = $clog2(NSTAT),
  localparam int FIDX_W = $clog2(NFID)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [TIME_W-1:0] cfg_slot_len_i,
  input  logic [SIDX_W:0]   cfg_static_slots_i,
  input  logic [TIME_W-1:0] cfg_minislot_len_i,
  input  logic [MS_W-1:0]   cfg_dyn_minislots_i,
  input  logic [TIME_W-1:0] cfg_wait_len_i,
  input  logic [NFID-1:0]   cfg_own_fid_i,
  input  logic              sched_we_i,
  input  logic [SIDX_W-1:0] sched_addr_i,
  input  logic [1:0]        sched_act_i,
  input  logic [IDX_W-1:0]  sched_msg_i,
  input  logic              push_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic [MS_W-1:0]   push_len_i,
  input  logic [IDX_W-1:0]  push_msg_i,
  output logic              q_full_o,
  output logic [1:0]        seg_o,
  output logic [SIDX_W-1:0] slot_o,
  output logic [MS_W-1:0]   fid_o,
  output logic [1:0]        act_o,
  output logic              stat_tx_o,
  output logic              dyn_tx_o,
  output logic [IDX_W-1:0]  tx_msg_o,
  output logic [MS_W-1:0]   tx_len_o
);
  logic [TIME_W-1:0] slot_len_q, ms_len_q, wait_len_q;
  logic [SIDX_W:0]   nstat_q;
  logic [MS_W-1:0]   nms_q;
  logic [NFID-1:0]   own_q;

  seg_e              state_q;
  logic [TIME_W-1:0] tick_q;
  logic [SIDX_W-1:0] slot_q;
  logic [MS_W-1:0]   fid_q, ms_left_q, slot_ms_q;

  logic [TIME_W-1:0] cur_len;
  logic              tick_last, dyn_start, own_hit, take;
  logic [MS_W-1:0]   slot_ms_cur;
  logic [1:0]        tbl_act;
  logic [IDX_W-1:0]  tbl_msg;
  logic              q_vld;
  logic [MS_W-1:0]   q_len;
  logic [IDX_W-1:0]  q_msg;

  bcc_sched_table #(.NSTAT(NSTAT), .IDX_W(IDX_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i(sched_we_i), .waddr_i(sched_addr_i), .wact_i(sched_act_i),
    .wmsg_i(sched_msg_i), .raddr_i(slot_q), .ract_o(tbl_act), .rmsg_o(tbl_msg)
  );

  bcc_dyn_queue #(.DEPTH(QDEPTH), .PRIO_W(PRIO_W), .LEN_W(MS_W), .IDX_W(IDX_W)) u_q (
    .clk_i, .rst_ni,
    .push_i, .push_prio_i, .push_len_i, .push_msg_i(push_msg_i),
    .room_i(ms_left_q), .pop_i(take),
    .sel_vld_o(q_vld), .sel_len_o(q_len), .sel_msg_o(q_msg), .full_o(q_full_o)
  );

  always_comb begin
    unique case (state_q)
      SEG_STATIC: cur_len = slot_len_q;
      SEG_DYN:    cur_len = ms_len_q;
      default:    cur_len = wait_len_q;
    endcase
  end

  assign tick_last   = (tick_q == cur_len - TIME_W'(1));
  assign dyn_start   = (state_q == SEG_DYN) && (tick_q == '0) && (slot_ms_q == '0);
  assign own_hit     = (int'(fid_q) < NFID) && own_q[fid_q[FIDX_W-1:0]];
  assign take        = dyn_start && own_hit && q_vld;
  assign slot_ms_cur = dyn_start ? (take ? q_len : MS_W'(1)) : slot_ms_q;

  assign seg_o     = state_q;
  assign slot_o    = slot_q;
  assign fid_o     = (state_q == SEG_DYN) ? fid_q : '0;
  assign act_o     = (state_q == SEG_STATIC) ? tbl_act : ACT_IDLE;
  assign stat_tx_o = (state_q == SEG_STATIC) && (tick_q == '0) && (tbl_act == ACT_SEND);
  assign dyn_tx_o  = take;
  assign tx_msg_o  = stat_tx_o ? tbl_msg : (take ? q_msg : '0);
  assign tx_len_o  = take ? q_len : '0;

  // configuration opens only while disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_len_q <= TIME_W'(1);
      ms_len_q   <= TIME_W'(1);
      wait_len_q <= TIME_W'(1);
      nstat_q    <= (SIDX_W+1)'(1);
      nms_q      <= MS_W'(1);
      own_q      <= '0;
    end else if (!enable_i) begin
      slot_len_q <= cfg_slot_len_i;
      ms_len_q   <= cfg_minislot_len_i;
      wait_len_q <= cfg_wait_len_i;
      nstat_q    <= cfg_static_slots_i;
      nms_q      <= cfg_dyn_minislots_i;
      own_q      <= cfg_own_fid_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= SEG_OFF;
      tick_q    <= '0;
      slot_q    <= '0;
      fid_q     <= '0;
      ms_left_q <= '0;
      slot_ms_q <= '0;
    end else if (!enable_i) begin
      state_q   <= SEG_OFF;
      tick_q    <= '0;
      slot_q    <= '0;
      fid_q     <= '0;
      ms_left_q <= '0;
      slot_ms_q <= '0;
    end else begin
      unique case (state_q)
        SEG_OFF: begin
          state_q <= SEG_STATIC;
          tick_q  <= '0;
          slot_q  <= '0;
        end
        SEG_STATIC: begin
          if (tick_last) begin
            tick_q <= '0;
            if ({1'b0, slot_q} == nstat_q - (SIDX_W+1)'(1)) begin
              state_q   <= SEG_DYN;
              slot_q    <= '0;
              fid_q     <= '0;
              ms_left_q <= nms_q;
              slot_ms_q <= '0;
            end else begin
              slot_q <= slot_q + SIDX_W'(1);
            end
          end else begin
            tick_q <= tick_q + TIME_W'(1);
          end
        end
        SEG_DYN: begin
          slot_ms_q <= slot_ms_cur;
          if (tick_last) begin
            tick_q    <= '0;
            slot_ms_q <= slot_ms_cur - MS_W'(1);
            ms_left_q <= ms_left_q - MS_W'(1);
            if (slot_ms_cur == MS_W'(1)) fid_q <= fid_q + MS_W'(1);
            if (ms_left_q == MS_W'(1)) begin
              state_q   <= SEG_WAIT;
              fid_q     <= '0;
              slot_ms_q <= '0;
            end
          end else begin
            tick_q <= tick_q + TIME_W'(1);
          end
        end
        default: begin
          if (tick_last) begin
            state_q <= SEG_STATIC;
            tick_q  <= '0;
            slot_q  <= '0;
          end else begin
            tick_q <= tick_q + TIME_W'(1);
          end
        end
      endcase
    end
  end

  AST_DYN_AFTER_STATIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SEG_DYN && $past(state_q) != SEG_DYN |-> $past(state_q) == SEG_STATIC); // R1
  AST_WAIT_AFTER_DYN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SEG_WAIT && $past(state_q) != SEG_WAIT |-> $past(state_q) == SEG_DYN); // R9
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stat_tx_o && dyn_tx_o)); // R2
  AST_DTX_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dyn_tx_o |-> tx_len_o <= ms_left_q); // R7
  AST_FID_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == SEG_DYN && $past(state_q) == SEG_DYN
      |-> fid_q == $past(fid_q) || fid_q == $past(fid_q) + MS_W'(1)); // R4
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && $past(enable_i) |=> $stable(own_q) && $stable(nms_q)); // R10
endmodule

// File: tb/bus_cycle_ctrl_tb_top.sv
module bus_cycle_ctrl_tb_top;
  localparam int NSTAT = 16, TIME_W = 8, MS_W = 8, NFID = 16, PRIO_W = 3, IDX_W = 4;
  localparam int SIDX_W = $clog2(NSTAT);
  localparam int NVEC = 20;
  // {t, seg, act, fid, stat_tx, dyn_tx, msg, len}
  localparam logic [33:0] VEC [NVEC] = '{
    {8'd0,  2'd1, 2'd1, 8'd0, 1'b1, 1'b0, 4'd5, 8'd0},
    {8'd1,  2'd1, 2'd1, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd4,  2'd1, 2'd2, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd8,  2'd1, 2'd0, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd11, 2'd1, 2'd0, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd12, 2'd2, 2'd0, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd14, 2'd2, 2'd0, 8'd1, 1'b0, 1'b1, 4'd2, 8'd2},
    {8'd16, 2'd2, 2'd0, 8'd1, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd18, 2'd2, 2'd0, 8'd2, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd20, 2'd2, 2'd0, 8'd3, 1'b0, 1'b1, 4'd3, 8'd1},
    {8'd22, 2'd2, 2'd0, 8'd4, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd27, 2'd2, 2'd0, 8'd6, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd28, 2'd3, 2'd0, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd30, 2'd3, 2'd0, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd31, 2'd1, 2'd1, 8'd0, 1'b1, 1'b0, 4'd5, 8'd0},
    {8'd43, 2'd2, 2'd0, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd45, 2'd2, 2'd0, 8'd1, 1'b0, 1'b1, 4'd1, 8'd3},
    {8'd51, 2'd2, 2'd0, 8'd2, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd53, 2'd2, 2'd0, 8'd3, 1'b0, 1'b0, 4'd0, 8'd0},
    {8'd59, 2'd3, 2'd0, 8'd0, 1'b0, 1'b0, 4'd0, 8'd0}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, enable_i = 1'b0;
  logic [TIME_W-1:0] cfg_slot_len_i, cfg_minislot_len_i, cfg_wait_len_i;
  logic [SIDX_W:0]   cfg_static_slots_i;
  logic [MS_W-1:0]   cfg_dyn_minislots_i;
  logic [NFID-1:0]   cfg_own_fid_i;
  logic              sched_we_i = 1'b0;
  logic [SIDX_W-1:0] sched_addr_i = '0;
  logic [1:0]        sched_act_i = '0;
  logic [IDX_W-1:0]  sched_msg_i = '0;
  logic              push_i = 1'b0;
  logic [PRIO_W-1:0] push_prio_i = '0;
  logic [MS_W-1:0]   push_len_i = '0;
  logic [IDX_W-1:0]  push_msg_i = '0;
  logic              q_full_o, stat_tx_o, dyn_tx_o;
  logic [1:0]        seg_o, act_o;
  logic [SIDX_W-1:0] slot_o;
  logic [MS_W-1:0]   fid_o, tx_len_o;
  logic [IDX_W-1:0]  tx_msg_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 1'b0;

  bus_cycle_ctrl dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_cfg();
    cfg_slot_len_i = 8'd4;  cfg_static_slots_i = 5'd3; cfg_minislot_len_i = 8'd2;
    cfg_dyn_minislots_i = 8'd8; cfg_wait_len_i = 8'd3; cfg_own_fid_i = 16'h000a;
  endtask

  task automatic push(input int p, input int l, input int m);
    @(negedge clk_i);
    push_i = 1'b1; push_prio_i = PRIO_W'(p); push_len_i = MS_W'(l); push_msg_i = IDX_W'(m);
    @(negedge clk_i);
    push_i = 1'b0;
  endtask

  task automatic sched(input int a, input int act, input int m);
    @(negedge clk_i);
    sched_we_i = 1'b1; sched_addr_i = SIDX_W'(a); sched_act_i = 2'(act); sched_msg_i = IDX_W'(m);
    @(negedge clk_i);
    sched_we_i = 1'b0;
  endtask

  task automatic wait_dtx(output int t, output int m, output int l, output int f);
    t = -1; m = 255; l = 255; f = 255;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk_i);
      if (dyn_tx_o) begin
        t = k; m = int'(tx_msg_o); l = int'(tx_len_o); f = int'(fid_o);
        break;
      end
    end
  endtask

  task automatic go(input bit en);
    @(negedge clk_i);
    enable_i = en;
  endtask

  initial begin
    int vi, n_stx, n_dtx, t, m, l, f;
    set_cfg();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset seg", seg_o, 0);
    chk("R11 reset full", q_full_o, 0);
    chk("R2 reset strobes", {stat_tx_o, dyn_tx_o}, 0);

    sched(0, 1, 5); sched(1, 2, 0); sched(2, 0, 0);
    push(2, 3, 1); push(1, 2, 2); push(0, 0, 14); push(1, 1, 3); push(0, 9, 4);

    // vector walk; config scrambled while enabled (R10)
    @(negedge clk_i);
    enable_i = 1'b1;
    cfg_slot_len_i = 8'd7; cfg_static_slots_i = 5'd5; cfg_minislot_len_i = 8'd3;
    cfg_dyn_minislots_i = 8'd9; cfg_wait_len_i = 8'd1; cfg_own_fid_i = 16'hffff;
    vi = 0; n_stx = 0; n_dtx = 0;
    for (int tt = 0; tt < 62; tt++) begin
      @(negedge clk_i);
      n_stx += int'(stat_tx_o);
      n_dtx += int'(dyn_tx_o);
      if (vi < NVEC && tt == int'(VEC[vi][33:26])) begin
        case (VEC[vi][25:24])
          2'd1:    chk("R2 R3 R10 static vector", {seg_o, act_o, fid_o, stat_tx_o, dyn_tx_o, tx_msg_o, tx_len_o}, VEC[vi][25:0]);
          2'd2:    chk("R4 R5 R7 R8 R11 dynamic vector", {seg_o, act_o, fid_o, stat_tx_o, dyn_tx_o, tx_msg_o, tx_len_o}, VEC[vi][25:0]);
          default: chk("R1 R9 wait vector", {seg_o, act_o, fid_o, stat_tx_o, dyn_tx_o, tx_msg_o, tx_len_o}, VEC[vi][25:0]);
        endcase
        vi++;
      end
    end
    chk("R2 static strobe count", n_stx, 2);
    chk("R5 dynamic strobe count", n_dtx, 3);
    go(1'b0);
    set_cfg();
    @(negedge clk_i);
    chk("R1 disabled seg", seg_o, 0);

    // exact fit and slot stretch: 3 minislots, own frame 0
    cfg_dyn_minislots_i = 8'd3; cfg_own_fid_i = 16'h0001;
    push(0, 4, 6); push(1, 3, 7);
    go(1'b1);
    wait_dtx(t, m, l, f);
    chk("R7 exact fit msg", m, 7);
    chk("R7 exact fit len", l, 3);
    chk("R5 owned frame", f, 0);
    chk("R3 dyn start time", t, 12);
    repeat (5) @(negedge clk_i);
    chk("R8 stretched slot still dynamic", seg_o, 2);
    @(negedge clk_i);
    chk("R8 segment end after stretch", seg_o, 3);
    go(1'b0);

    // arrival order among equal priorities
    push(3, 1, 8); push(3, 1, 9);
    go(1'b1);
    wait_dtx(t, m, l, f);
    chk("R6 first of equal priority", m, 8);
    wait_dtx(t, m, l, f);
    chk("R6 second of equal priority", m, 9);
    go(1'b0);

    // full queue drops an urgent push
    for (int k = 0; k < 6; k++) push(5, 1, k);
    @(negedge clk_i);
    chk("R11 full flag", q_full_o, 1);
    push(0, 1, 15);
    go(1'b1);
    wait_dtx(t, m, l, f);
    chk("R11 dropped push not sent", m, 0);
    go(1'b0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule